// File: doc/BRIEF.md
# Bit-String Memory Test-and-Modify Unit

This block executes one bit-test operation on a bit string held in memory: test only, test-and-set, test-and-clear or test-and-invert. A request carries a base byte address, a bit offset, a flag that selects between an immediate offset and a register offset, an operand size code and an operation code. The unit turns these into a word address and a bit index, reads one operand-sized word over a request/ready memory port, reports the old value of the chosen bit as a carry flag, and writes the altered word back unless the operation only tests.

The two offset forms differ. A register offset is a signed number taken at the operand width, and it moves the accessed word away from the base address in whole-word steps, downwards for negative values. An immediate offset never moves the address. It only picks a bit inside the word that starts at the base address, and any offset bits above the index field are dropped.

A new request is taken only while the unit is idle. A one-cycle `done` pulse marks the end of each operation.

Top module: `bitstr_rmw`

## Requirements
- R1: With `off_is_imm`=1 the word address equals `base_addr`. The bit index is the low 4, 5 or 6 bits of `bit_off` for size code 0, 1 or 2 (2, 4 or 8 bytes), and all higher offset bits are ignored.
- R2: With `off_is_imm`=0 the low 16, 32 or 64 bits of `bit_off` are read as a two's-complement number s, and higher bits are ignored. The word address is `base_addr` + bytes × floor(s / bits), wrapping modulo 2^64.
- R3: In register form the bit index is s − bits × floor(s / bits), which always lies in 0..bits−1. Bit i of the word is bit i of `mem_rdata`/`mem_wdata`, with bytes in little-endian order. `mem_size` repeats the size code (0 = 2 bytes, 1 = 4 bytes, 2 = 8 bytes).
- R4: While `done` is high, `cf` holds the value the chosen bit had in the word that was read.
- R5: Operation codes 01, 10 and 11 write the word that was read, with the chosen bit forced to 1, forced to 0 or inverted. Every `mem_wdata` bit above the operand width is 0.
- R6: Operation code 00 performs no write cycle. `done` rises in the cycle after the read data is taken.
- R7: A request (`mem_req`=1, `mem_we` 0 for a read and 1 for a write) is held with stable address and data until a cycle with `mem_ready`=1. After the read request is accepted, `mem_req` is low, and the next `mem_ready` marks `mem_rdata` as valid. The write request follows, and after it is accepted `done` is high for exactly one cycle.
- R8: `start` is taken only while `busy`=0. A `start` while busy changes neither the operation in progress nor the address it uses, and it does not begin another operation.
- R9: After reset `busy`, `done`, `mem_req` and `cf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken when idle) |
| base_addr | input | 64 | Base byte address of the bit string |
| bit_off | input | 64 | Bit offset (immediate or register value) |
| off_is_imm | input | 1 | 1 = immediate offset, 0 = register offset |
| op_size | input | 2 | 0 = 2 bytes, 1 = 4 bytes, 2 = 8 bytes |
| op_code | input | 2 | 00 test, 01 set, 10 clear, 11 invert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cf | output | 1 | Old value of the chosen bit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 64 | Word byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
The read request appears one cycle after `start` is taken, and it carries the address and size computed from the latched operands. `mem_req` drops one cycle after a `mem_ready` accepts it. For test operations `done` and `cf` follow one cycle after the data-valid `mem_ready`. For the other operations the write request appears in that cycle instead, and `done` follows one cycle after the write is accepted. The bench drives every input and samples every output on the falling edge. It steps through this schedule one cycle at a time with varied ready latencies, so each value is checked in the exact cycle it is due and not merely at some point later.

// File: rtl/bitstr_pkg.sv
package bitstr_pkg;

    localparam int BT_ADDR_W = 64;
    localparam int BT_DATA_W = 64;
    localparam int BT_POS_W  = $clog2(BT_DATA_W);

    typedef enum logic [1:0] {
        BT_TEST  = 2'b00,
        BT_SET   = 2'b01,
        BT_CLEAR = 2'b10,
        BT_FLIP  = 2'b11
    } bt_op_e;

    typedef enum logic [1:0] {
        SZ_W16 = 2'd0,
        SZ_W32 = 2'd1,
        SZ_W64 = 2'd2,
        SZ_RSV = 2'd3
    } bt_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_REQ,
        ST_WAIT_RDATA,
        ST_WRITE_REQ,
        ST_DONE
    } bt_state_e;

    typedef struct packed {
        bt_op_e   op;
        bt_size_e size;
    } bt_ctl_t;

    // Index of the size variant; the reserved code behaves as the widest one.
    function automatic int unsigned size_index(input bt_size_e sz);
        case (sz)
            SZ_W16:  return 0;
            SZ_W32:  return 1;
            default: return 2;
        endcase
    endfunction

    // Mask covering the operand width inside the data bus.
    function automatic logic [BT_DATA_W-1:0] word_mask(input bt_size_e sz);
        case (sz)
            SZ_W16:  return BT_DATA_W'(16'hFFFF);
            SZ_W32:  return BT_DATA_W'(32'hFFFF_FFFF);
            default: return {BT_DATA_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/bitstr_addr_gen.sv
module bitstr_addr_gen
    import bitstr_pkg::*;
#(
    parameter int ADDR_W = BT_ADDR_W,
    parameter int DATA_W = BT_DATA_W
) (
    input  logic [ADDR_W-1:0]          base,
    input  logic [ADDR_W-1:0]          off,
    input  logic                       is_imm,
    input  bt_size_e                   size,
    output logic [ADDR_W-1:0]          eff_addr,
    output logic [$clog2(DATA_W)-1:0]  bit_pos
);
    localparam int POS_W = $clog2(DATA_W);
    localparam int N_SZ  = POS_W - 3;

    logic [ADDR_W-1:0] cand_addr [N_SZ];
    logic [POS_W-1:0]  cand_pos  [N_SZ];

    generate
        for (genvar g = 0; g < N_SZ; g++) begin : g_size
            localparam int LB = 4 + g;
            localparam int W  = 1 << LB;
            localparam int SH = ADDR_W - W;
            logic signed [ADDR_W-1:0] sx;
            logic signed [ADDR_W-1:0] disp;
            // sign-extend the offset at the operand width
            assign sx   = $signed(off << SH) >>> SH;
            // floor(s / bits) scaled to bytes
            assign disp = (sx >>> LB) <<< (LB - 3);
            assign cand_addr[g] = base + disp;
            assign cand_pos[g]  = POS_W'(off[LB-1:0]);
        end
    endgenerate

    int unsigned idx;
    always_comb begin
        idx      = size_index(size);
        eff_addr = is_imm ? base : cand_addr[idx];
        bit_pos  = cand_pos[idx];
    end

endmodule

// File: rtl/bitstr_bit_alu.sv
module bitstr_bit_alu
    import bitstr_pkg::*;
#(
    parameter int DATA_W = BT_DATA_W
) (
    input  logic [DATA_W-1:0]          rd_word,
    input  logic [$clog2(DATA_W)-1:0]  bit_pos,
    input  bt_op_e                     op,
    input  bt_size_e                   size,
    output logic                       old_bit,
    output logic [DATA_W-1:0]          wr_word
);
    logic [DATA_W-1:0] sel;
    logic [DATA_W-1:0] mod;

    always_comb begin
        sel     = DATA_W'(1) << bit_pos;
        old_bit = rd_word[bit_pos];
        case (op)
            BT_SET:   mod = rd_word | sel;
            BT_CLEAR: mod = rd_word & ~sel;
            BT_FLIP:  mod = rd_word ^ sel;
            default:  mod = rd_word;
        endcase
        wr_word = mod & word_mask(size);
    end

endmodule

// File: rtl/bitstr_ctrl.sv
module bitstr_ctrl
    import bitstr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      is_test,
    input  logic      mem_ready,
    output logic      accept,
    output logic      capture,
    output logic      busy,
    output logic      done,
    output logic      mem_req,
    output logic      mem_we
);
    bt_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        capture  = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                accept   = 1'b1;
                state_nx = ST_READ_REQ;
            end
            ST_READ_REQ:   if (mem_ready) state_nx = ST_WAIT_RDATA;
            ST_WAIT_RDATA: if (mem_ready) begin
                capture  = 1'b1;
                state_nx = is_test ? ST_DONE : ST_WRITE_REQ;
            end
            ST_WRITE_REQ:  if (mem_ready) state_nx = ST_DONE;
            ST_DONE:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign mem_req = (state == ST_READ_REQ) || (state == ST_WRITE_REQ);
    assign mem_we  = (state == ST_WRITE_REQ);

    // R6: a test finishes directly after its read data
    assert_test_done_R6: assert property (@(posedge clk) disable iff (rst)
        (capture && is_test) |=> (done && !mem_req));

    // R7: a write request follows the read data of a modifying operation
    assert_write_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (capture && !is_test) |=> (mem_req && mem_we));

endmodule

// File: rtl/bitstr_rmw.sv
module bitstr_rmw
    import bitstr_pkg::*;
#(
    parameter int ADDR_W = BT_ADDR_W,
    parameter int DATA_W = BT_DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [ADDR_W-1:0]  bit_off,
    input  logic               off_is_imm,
    input  logic [1:0]         op_size,
    input  logic [1:0]         op_code,
    output logic               busy,
    output logic               done,
    output logic               cf,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [1:0]         mem_size,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ready,
    input  logic [DATA_W-1:0]  mem_rdata
);
    localparam int POS_W = $clog2(DATA_W);

    bt_ctl_t           ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [POS_W-1:0]  pos_q;
    logic [DATA_W-1:0] rd_q;

    logic [ADDR_W-1:0] ea;
    logic [POS_W-1:0]  ea_pos;
    logic              accept, capture;

    bitstr_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .base     (base_addr),
        .off      (bit_off),
        .is_imm   (off_is_imm),
        .size     (bt_size_e'(op_size)),
        .eff_addr (ea),
        .bit_pos  (ea_pos)
    );

    bitstr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_test   (ctl_q.op == BT_TEST),
        .mem_ready (mem_ready),
        .accept    (accept),
        .capture   (capture),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we)
    );

    bitstr_bit_alu #(.DATA_W(DATA_W)) u_alu (
        .rd_word (rd_q),
        .bit_pos (pos_q),
        .op      (ctl_q.op),
        .size    (ctl_q.size),
        .old_bit (cf),
        .wr_word (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{op: BT_TEST, size: SZ_W16};
            addr_q <= '0;
            pos_q  <= '0;
            rd_q   <= '0;
        end else begin
            if (accept) begin
                ctl_q  <= '{op: bt_op_e'(op_code), size: bt_size_e'(op_size)};
                addr_q <= ea;
                pos_q  <= ea_pos;
            end
            if (capture) rd_q <= mem_rdata;
        end
    end

    assign mem_addr = addr_q;
    assign mem_size = ctl_q.size;

    // R7: an unaccepted request stays put
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=>
        (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R7: done lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: test-only never writes
    assert_test_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (ctl_q.op != BT_TEST));

    // R8: start while busy leaves the address alone
    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mem_addr));

    // R1: immediate form reads at the base address
    assert_imm_addr_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && off_is_imm) |=> (mem_addr == $past(base_addr)));

    // R5: set writes a one into the chosen bit
    assert_set_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && ctl_q.op == BT_SET) |-> mem_wdata[pos_q]);

endmodule

// File: tb/test_bitstr_rmw.sv
module test_bitstr_rmw;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] base_addr = '0;
    logic [63:0] bit_off = '0;
    logic        off_is_imm = 1'b0;
    logic [1:0]  op_size = '0;
    logic [1:0]  op_code = '0;
    logic        busy, done, cf, mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    bitstr_rmw i_bitstr_rmw (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .bit_off(bit_off), .off_is_imm(off_is_imm), .op_size(op_size),
        .op_code(op_code), .busy(busy), .done(done), .cf(cf),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pattern(input logic [63:0] a);
        return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'hA5C3_0F69_5A3C_F096;
    endfunction

    function automatic logic [63:0] offset_of(input int i);
        case (i)
            0:  return 64'd0;
            1:  return 64'd1;
            2:  return 64'd7;
            3:  return 64'd15;
            4:  return 64'd16;
            5:  return 64'd17;
            6:  return 64'd31;
            7:  return 64'd32;
            8:  return 64'd63;
            9:  return 64'd64;
            10: return -64'sd1;
            11: return -64'sd17;
            12: return 64'd12345;
            13: return -64'sd100000;
            14: return 64'h8000_0000_0000_0000;
            15: return 64'h7FFF_FFFF_FFFF_FFFF;
            16: return 64'h1234_5678_9ABC_DEF0;
            default: return 64'hFFFF_0000_0000_8000;
        endcase
    endfunction

    // expected address and bit index, computed from the arithmetic definition
    task automatic expect_loc(input logic [63:0] base, input logic [63:0] off,
                              input bit imm, input int sz,
                              output logic [63:0] ea, output int pos);
        int w = 1 << (4 + sz);
        longint sx, q;
        if (imm) begin
            ea  = base;
            pos = int'(off & 64'(w - 1));
        end else begin
            sx = $signed(off << (64 - w)) >>> (64 - w);
            q  = sx / w;
            if ((sx % w) != 0 && sx < 0) q = q - 1;
            ea  = base + 64'(q * (w / 8));
            pos = int'(sx - q * w);
        end
    endtask

    task automatic run_op(input logic [63:0] base, input logic [63:0] off,
                          input bit imm, input int sz, input int op, input int lat);
        logic [63:0] ea, word, mask, exp_w;
        int pos;
        int w = 1 << (4 + sz);
        expect_loc(base, off, imm, sz, ea, pos);
        mask = (w == 64) ? '1 : ((64'd1 << w) - 1);

        @(negedge clk);
        base_addr = base; bit_off = off; off_is_imm = imm;
        op_size = 2'(sz); op_code = 2'(op); start = 1'b1;
        @(negedge clk);
        // junk request while busy (R8)
        base_addr = ~base; bit_off = off + 64'd77; off_is_imm = ~imm;
        chk("R7", "read req", {62'd0, mem_req, mem_we}, 64'b10);
        chk(imm ? "R1" : "R2", "read addr", mem_addr, ea);
        chk("R3", "size code", 64'(mem_size), 64'(sz));
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk("R7", "req held", {63'd0, mem_req}, 64'd1);
            chk("R8", "addr kept", mem_addr, ea);
        end
        start = 1'b0;
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R7", "req low while waiting data", {63'd0, mem_req}, 64'd0);
        for (int k = 0; k < (lat + 1) % 3; k++) @(negedge clk);
        word = pattern(ea);
        mem_rdata = word;
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        mem_rdata = '0;
        word = word & mask;
        if (op == 0) begin
            chk("R6", "done after read", {62'd0, done, mem_req}, 64'b10);
        end else begin
            case (op)
                1: exp_w = word | (64'd1 << pos);
                2: exp_w = word & ~(64'd1 << pos);
                default: exp_w = word ^ (64'd1 << pos);
            endcase
            chk("R7", "write req", {62'd0, mem_req, mem_we}, 64'b11);
            chk("R5", "wdata", mem_wdata, exp_w);
            chk(imm ? "R1" : "R2", "write addr", mem_addr, ea);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk("R7", "write held", {62'd0, mem_req, mem_we}, 64'b11);
            end
            mem_ready = 1'b1;
            @(negedge clk);
            mem_ready = 1'b0;
        end
        chk("R7", "done", {63'd0, done}, 64'd1);
        chk("R4", "carry flag", {63'd0, cf}, {63'd0, word[pos]});
        @(negedge clk);
        chk("R7", "done one cycle", {63'd0, done}, 64'd0);
        chk("R8", "idle after done", {62'd0, busy, mem_req}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "reset outputs", {60'd0, busy, done, mem_req, cf}, 64'd0);

        for (int sz = 0; sz < 3; sz++)
            for (int imm = 0; imm < 2; imm++)
                for (int op = 0; op < 4; op++)
                    for (int i = 0; i < 18; i++)
                        run_op((i % 3 == 0) ? 64'd3 : 64'h0000_4000_0000_1000 + 64'(i * 40),
                               imm ? (offset_of(i) & 64'hFF) | 64'h5500 : offset_of(i),
                               imm[0], sz, op, (i + op + sz) % 3);

        // wrap below address zero in register form (R2)
        run_op(64'd0, -64'sd17, 1'b0, 1, 3, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule